// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped controller for a bank of general-purpose pins. The pin count is a parameter and must be a multiple of 32. Software reaches the block through a plain 32-bit register port, which takes a byte address, a write enable and write data, and returns combinational read data. For each pin the block provides:

- a readback of the pin level, taken through a two-flop synchronizer;
- a direction bit;
- an output latch, changed through separate write-one-to-set and write-one-to-clear words;
- independent enables for rising and falling edges;
- a sticky edge flag, cleared by writing one;
- a 2-bit alternate-function code.

Registers are grouped by feature. The groups follow each other in a fixed order, and each group fills as many consecutive 32-bit words as the pin count needs. One active-high interrupt line stays up while any pin has an edge flag set. Pad drivers, bus bridging and interrupt acknowledgement belong to the logic around the block.

Top module: `gpio_bank`

## Requirements
- R1: With W = NUM_PINS/32, the byte address of the word that holds pin p's bit for feature code f is f*W*4 + (p/32)*4, and the bit is p%32. The feature codes are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge flag, 7 alternate function. Address bits [1:0] are ignored.
- R2: A read of a level word returns the pin inputs two clock edges after they change. Writes to level words change nothing.
- R3: Writing a 1 to a bit of a set word drives that pin's output latch high. Writing a 1 to a bit of a clear word drives it low. Zero bits leave their latch unchanged. Set and clear words read as 0.
- R4: A direction bit of 1 raises pinOe for that pin, which makes it an output. A 0 makes it an input. Direction words read back as written.
- R5: When a pin's rising enable is 1, a 0-to-1 change of its synchronized level sets its edge flag on the third clock edge after the input changes.
- R6: When a pin's falling enable is 1, a 1-to-0 change sets its edge flag with the same latency as R5. A change in the direction that is not enabled sets nothing.
- R7: Writing a 1 to an edge-flag bit clears it, and zero bits leave their flags unchanged. If an edge sets a flag on the same clock edge that a clear write to that bit takes effect, the flag stays at 1.
- R8: Each alternate-function code is 2 bits wide, with 16 pins per word. Pin p's code is in word p/16 of the group that starts at byte 7*W*4, at bits (p%16)*2+1:(p%16)*2. It reads back as written and appears on altSel[2p+1:2p]. Code 0 means plain GPIO.
- R9: irq is 1 exactly when at least one edge flag is set.
- R10: After reset, every enable, edge flag, direction bit, output latch and alternate-function code is 0.
- R11: Addresses at or beyond byte 9*W*4 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe; one write per cycle in which it is high |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| pinIn | input | NUM_PINS | Pin levels from the pads |
| pinOut | output | NUM_PINS | Output latch values |
| pinOe | output | NUM_PINS | Output enables (direction bits) |
| altSel | output | 2*NUM_PINS | Alternate-function code per pin |
| irq | output | 1 | Level interrupt: OR of all edge flags |

## Verification
An edge flag that is wrongly set or lost shows on irq and in the flag word on the very next edge, so the bench compares every output and the read data on every cycle. Set/clear state shows directly on pinOut. An address decode that picks the wrong word or group shows the first time the word is read back or drives an output. Because the synchronizer delay is checked cycle by cycle, a missing or extra stage shows as a one-cycle shift on the first toggle with edges enabled. The case of a clear and an edge on the same clock edge is driven on purpose.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int IDX_W = 8;
  localparam int NFEAT = 8;

  // Feature group order fixes the address map; do not reorder.
  typedef enum logic [2:0] {
    FT_LEVEL = 3'd0,
    FT_DIR   = 3'd1,
    FT_SET   = 3'd2,
    FT_CLR   = 3'd3,
    FT_RISE  = 3'd4,
    FT_FALL  = 3'd5,
    FT_FLAG  = 3'd6,
    FT_ALT   = 3'd7
  } feat_e;

  typedef struct packed {
    logic             hit;     // address maps to a register word
    feat_e            feat;    // selected feature group
    logic [IDX_W-1:0] idx;     // word index within the group
    logic [NFEAT-1:0] wrStrb;  // one-hot write strobe per group
  } bus_strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output bus_strobe_t       strb
);
  localparam int unsigned NREG  = NUM_PINS / 32;
  localparam int unsigned BASE7 = 7 * NREG;
  localparam int unsigned WORDS = 9 * NREG;

  always_comb begin
    int unsigned wordNum;
    wordNum = 32'(busAddr[ADDR_W-1:2]);
    strb = '0;
    if (wordNum < BASE7) begin
      strb.hit  = 1'b1;
      strb.feat = feat_e'(3'(wordNum / NREG));
      strb.idx  = IDX_W'(wordNum % NREG);
    end else if (wordNum < WORDS) begin
      strb.hit  = 1'b1;
      strb.feat = FT_ALT;
      strb.idx  = IDX_W'(wordNum - BASE7);
    end
    if (strb.hit && busWrEn) strb.wrStrb[strb.feat] = 1'b1;
  end

  // R11: no group sees a write strobe for an unmapped address
  p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (32'(busAddr[ADDR_W-1:2]) >= WORDS) |-> (strb.wrStrb == '0));
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bus_strobe_t           strb,
  input  logic [31:0]           wrData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [31:0]           rdData,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [2*NUM_PINS-1:0] altSel,
  output logic                  irq
);
  localparam int NREG = NUM_PINS / 32;
  localparam int NALT = NUM_PINS / 16;

  logic [NUM_PINS-1:0]   syncA, syncB, prevB;
  logic [NUM_PINS-1:0]   dirReg, outReg, riseEn, fallEn, edgeFlag;
  logic [NUM_PINS-1:0]   edgeHit, flagClr;
  logic [2*NUM_PINS-1:0] altReg;

  // Two-flop synchronizer plus the previous sample for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign edgeHit = (syncB & ~prevB & riseEn) | (~syncB & prevB & fallEn);

  always_comb begin
    flagClr = '0;
    for (int w = 0; w < NREG; w++)
      if (strb.wrStrb[FT_FLAG] && strb.idx == IDX_W'(w)) flagClr[w*32 +: 32] = wrData;
  end

  // Configuration and output latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      outReg <= '0;
      riseEn <= '0;
      fallEn <= '0;
      altReg <= '0;
    end else begin
      for (int w = 0; w < NREG; w++) begin
        if (strb.idx == IDX_W'(w)) begin
          if (strb.wrStrb[FT_DIR])  dirReg[w*32 +: 32] <= wrData;
          if (strb.wrStrb[FT_SET])  outReg[w*32 +: 32] <= outReg[w*32 +: 32] | wrData;
          if (strb.wrStrb[FT_CLR])  outReg[w*32 +: 32] <= outReg[w*32 +: 32] & ~wrData;
          if (strb.wrStrb[FT_RISE]) riseEn[w*32 +: 32] <= wrData;
          if (strb.wrStrb[FT_FALL]) fallEn[w*32 +: 32] <= wrData;
        end
      end
      for (int a = 0; a < NALT; a++)
        if (strb.wrStrb[FT_ALT] && strb.idx == IDX_W'(a)) altReg[a*32 +: 32] <= wrData;
    end
  end

  // Sticky flags: a new edge wins over a coincident clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeFlag <= '0;
    else       edgeFlag <= (edgeFlag & ~flagClr) | edgeHit;
  end

  always_comb begin
    rdData = '0;
    if (strb.hit) begin
      if (strb.feat == FT_ALT) begin
        for (int a = 0; a < NALT; a++)
          if (strb.idx == IDX_W'(a)) rdData = altReg[a*32 +: 32];
      end else begin
        for (int w = 0; w < NREG; w++) begin
          if (strb.idx == IDX_W'(w)) begin
            case (strb.feat)
              FT_LEVEL: rdData = syncB[w*32 +: 32];
              FT_DIR:   rdData = dirReg[w*32 +: 32];
              FT_RISE:  rdData = riseEn[w*32 +: 32];
              FT_FALL:  rdData = fallEn[w*32 +: 32];
              FT_FLAG:  rdData = edgeFlag[w*32 +: 32];
              default:  rdData = '0;
            endcase
          end
        end
      end
    end
  end

  assign pinOut = outReg;
  assign pinOe  = dirReg;
  assign altSel = altReg;
  assign irq    = |edgeFlag;

  // R3: set and clear words act on the first word's latches
  p_set_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStrb[FT_SET] && strb.idx == '0) |=> ((outReg[31:0] & $past(wrData)) == $past(wrData)));
  p_clr_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStrb[FT_CLR] && strb.idx == '0) |=> ((outReg[31:0] & $past(wrData)) == '0));
  // R5 / R6: a flag only rises after an enabled edge was seen
  p_flag_needs_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((edgeFlag & ~$past(edgeFlag) & ~$past(edgeHit)) == '0));
  // R7: flags stay set unless cleared; a detected edge is never lost
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(edgeFlag) & ~$past(flagClr) & ~edgeFlag) == '0));
  p_edge_not_lost_r7: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHit != '0) |=> ((edgeFlag & $past(edgeHit)) == $past(edgeHit)));
  // R9: the interrupt rises only after an edge was captured
  p_irq_from_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(edgeHit != '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [2*NUM_PINS-1:0] altSel,
  output logic                  irq
);
  bus_strobe_t strb;

  gpio_bank_ctrl #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .pinIn(pinIn),
    .rdData(busRdData), .pinOut(pinOut), .pinOe(pinOe), .altSel(altSel), .irq(irq)
  );
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int NP = 64;
  localparam int NR = NP / 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [2*NP-1:0] altSel;
  logic irq;

  always #10 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .altSel(altSel), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string phase = "R10";

  // Behavioural reference state
  logic [NP-1:0] mDir, mOut, mRise, mFall, mFlag;
  logic [2*NP-1:0] mAlt;
  logic [NP-1:0] h1, h2, h3; // pin samples: latest, one older, two older

  function automatic int featOf(logic [AW-1:0] a);
    int wd = int'(a) / 4;
    if (wd < 7*NR) return wd / NR;
    if (wd < 9*NR) return 7;
    return -1;
  endfunction

  function automatic int idxOf(logic [AW-1:0] a);
    int wd = int'(a) / 4;
    if (wd < 7*NR) return wd % NR;
    return wd - 7*NR;
  endfunction

  function automatic logic [31:0] mRead(logic [AW-1:0] a);
    int f = featOf(a);
    int i = idxOf(a);
    case (f)
      0: return h2[i*32 +: 32];
      1: return mDir[i*32 +: 32];
      4: return mRise[i*32 +: 32];
      5: return mFall[i*32 +: 32];
      6: return mFlag[i*32 +: 32];
      7: return mAlt[i*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = '0; mOut = '0; mRise = '0; mFall = '0; mFlag = '0; mAlt = '0;
      h1 = '0; h2 = '0; h3 = '0;
    end else begin
      logic [NP-1:0] hitNow;
      int f;
      int i;
      hitNow = '0;
      for (int p = 0; p < NP; p++)
        if ((mRise[p] && h2[p] && !h3[p]) || (mFall[p] && !h2[p] && h3[p])) hitNow[p] = 1'b1;
      f = featOf(busAddr);
      i = idxOf(busAddr);
      if (busWrEn) begin
        case (f)
          1: mDir[i*32 +: 32] = busWrData;
          2: for (int b = 0; b < 32; b++) if (busWrData[b]) mOut[i*32+b] = 1'b1;
          3: for (int b = 0; b < 32; b++) if (busWrData[b]) mOut[i*32+b] = 1'b0;
          4: mRise[i*32 +: 32] = busWrData;
          5: mFall[i*32 +: 32] = busWrData;
          6: for (int b = 0; b < 32; b++) if (busWrData[b]) mFlag[i*32+b] = 1'b0;
          7: mAlt[i*32 +: 32] = busWrData;
          default: ;
        endcase
      end
      mFlag = mFlag | hitNow;
      h3 = h2; h2 = h1; h1 = pinIn;
    end
  end

  task automatic chk(string what, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", phase, what, got, exp);
    end
  endtask

  task automatic compareAll();
    chk("pinOut", 128'(pinOut), 128'(mOut));
    chk("pinOe", 128'(pinOe), 128'(mDir));
    chk("altSel", altSel, mAlt);
    chk("irq", 128'(irq), 128'(|mFlag));
    chk("busRdData", 128'(busRdData), 128'(mRead(busAddr)));
  endtask

  task automatic step();
    @(negedge clk);
    if (rstN) compareAll();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    busAddr = a;
    step();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phase = "R10";
    step(); step();
    chk("R10 reset pinOe", 128'(pinOe), 128'(0));
    rd(8'h30);

    phase = "R4";
    wr(8'h08, 32'hF0F0_0001);
    wr(8'h0C, 32'h8000_00FF);
    rd(8'h08); rd(8'h0C);
    chk("R4 pinOe word1", 128'(pinOe[63:32]), 128'(32'h8000_00FF));

    phase = "R3";
    wr(8'h10, 32'h0000_00FF);
    wr(8'h14, 32'hA5A5_0000);
    wr(8'h18, 32'h0000_000F);
    wr(8'h10, 32'h0);
    rd(8'h10); rd(8'h18); rd(8'h14);
    chk("R3 latch word0", 128'(pinOut[31:0]), 128'(32'h0000_00F0));
    chk("R3 set reads zero", 128'(busRdData), 128'(0));

    phase = "R2";
    pinIn = 64'h1234_5678_9ABC_DEF0;
    step(); step(); step();
    rd(8'h00);
    chk("R2 level word0", 128'(busRdData), 128'(32'h9ABC_DEF0));
    rd(8'h04);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00);
    chk("R2 level after write", 128'(busRdData), 128'(32'h9ABC_DEF0));

    phase = "R5";
    pinIn = '0;
    step(); step(); step();
    wr(8'h24, 32'h0000_0003);
    pinIn[33:32] = 2'b11;
    busAddr = 8'h34;
    step(); step();
    chk("R5 flag not yet", 128'(busRdData), 128'(0));
    step();
    chk("R5 flag on third edge", 128'(busRdData), 128'(3));
    chk("R5 irq", 128'(irq), 128'(1));

    phase = "R6";
    wr(8'h28, 32'h8000_0000);
    pinIn[31] = 1'b1;
    step(); step(); step(); step();
    rd(8'h30);
    chk("R6 rise ignored", 128'(busRdData), 128'(0));
    pinIn[31] = 1'b0;
    step(); step(); step(); step();
    rd(8'h30);
    chk("R6 fall flag", 128'(busRdData), 128'(32'h8000_0000));

    phase = "R7";
    wr(8'h34, 32'h0000_0001);
    rd(8'h34);
    chk("R7 w1c single", 128'(busRdData), 128'(2));
    wr(8'h20, 32'h0000_0008);
    pinIn[3] = 1'b1;
    step(); step();
    wr(8'h30, 32'h8000_0008);
    rd(8'h30);
    chk("R7 edge survives clear", 128'(busRdData), 128'(32'h0000_0008));

    phase = "R9";
    wr(8'h30, 32'h0000_0008);
    wr(8'h34, 32'h0000_0002);
    step();
    chk("R9 irq low", 128'(irq), 128'(0));

    phase = "R8";
    wr(8'h38, 32'h0000_0006);
    wr(8'h44, 32'hC000_0000);
    rd(8'h38); rd(8'h44);
    chk("R8 pin0 code", 128'(altSel[1:0]), 128'(2));
    chk("R8 pin1 code", 128'(altSel[3:2]), 128'(1));
    chk("R8 pin63 code", 128'(altSel[127:126]), 128'(3));

    phase = "R1";
    for (int a = 0; a < 9*NR; a++) rd(AW'(a*4));
    rd(8'h0F);
    chk("R1 low bits ignored", 128'(busRdData), 128'(32'h8000_00FF));

    phase = "R11";
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h48);
    chk("R11 unmapped read", 128'(busRdData), 128'(0));
    chk("R11 no side effect", 128'(pinOe), 128'(64'h8000_00FF_F0F0_0001));

    phase = "R5";
    wr(8'h20, 32'h0F0F_0F0F);
    wr(8'h28, 32'hFF00_FF00);
    wr(8'h24, 32'hFFFF_0000);
    wr(8'h2C, 32'h0000_FFFF);
    busAddr = 8'h30;
    for (int k = 0; k < 40; k++) begin
      pinIn = {32'(k * 32'h0101_0101), 32'(k * 32'h1357_9BDF)};
      if (k % 7 == 3) begin
        phase = "R7";
        busAddr = AW'(8'h30 + 4 * (k % 2));
        busWrEn = 1'b1; busWrData = 32'hFFFF_FFFF;
      end else begin
        phase = "R6";
        busWrEn = 1'b0;
      end
      step();
    end
    busWrEn = 1'b0;
    repeat (4) step();

    finishRun();
  end
endmodule